// File: doc/BRIEF.md
# Cut-Through Forwarding Engine

This block is the forwarding path between the ingress and egress ports of a small multi-port switch. Each ingress port supplies a byte stream with valid/ready handshaking and start and end-of-frame markers. The first six bytes of a frame hold the destination address. When the last of those six bytes is accepted, the block looks the address up in a small ternary match table. Each table entry holds a value, a care mask, a valid flag and an egress port number. The block then claims the chosen egress port. It emits a one-byte port tag and replays the six header bytes. After that the rest of the frame passes straight through while it is still arriving.

The block has no frame storage beyond the six header bytes. If the chosen egress port is already carrying another frame when the request is made, the block swallows the incoming frame and bumps that ingress port's drop counter. Frames that request the same free egress port on the same cycle are resolved by a fixed priority: the lowest ingress index wins and the others are dropped. Software loads the table through a single-cycle write port. A separate input gives the fallback port for addresses that match no entry.

Back-pressure rules: an output byte stays offered, unchanged, until its `out_ready` is high. During the lookup cycle and while the tag and header are replayed, the ingress port holds `in_ready` low. During pass-through, `in_ready` of the ingress port follows `out_ready` of its egress port, in the same cycle. Idle, header-collecting and discarding ingress ports keep `in_ready` high.

Top module: `csw_fwd_engine`

## Requirements
- R1: After reset every `out_valid` is low, every `in_ready` is high, every drop counter reads zero and every table entry is invalid, so all frames go to `dflt_port`.
- R2: A cycle with `tbl_we` high overwrites entry `tbl_idx` with value, mask, port and valid flag. Lookups made from the following cycle on use the new contents.
- R3: An entry matches when its valid flag is set and the address agrees with the entry value on every bit whose mask bit is 1. The address is the first six frame bytes, with the first byte in bits 47:40.
- R4: When several entries match, the lowest entry index selects the port. When none matches, `dflt_port` is used.
- R5: A forwarded frame leaves the egress port as one tag byte carrying the egress port number in its low bits (zero above), flagged with `out_sop`. Every ingress byte follows unchanged and in order, with `out_eop` on the last byte only.
- R6: The lookup runs in the cycle after the sixth byte is accepted. The tag is offered on the egress port in the cycle after that, long before a longer frame has fully arrived.
- R7: A frame whose egress port is owned by another frame at request time is consumed in full with `in_ready` high. It produces no egress bytes, and its ingress drop counter rises by exactly one.
- R8: Of frames requesting the same free egress port in the same cycle, the lowest ingress index is forwarded. Each of the others is dropped and counted.
- R9: Once granted, an egress port stays with its frame until that frame's last byte is transferred. The port is free for requests from the next cycle on, and a frame in flight is never cut short.
- R10: A frame whose end marker arrives within its first six bytes is discarded and counted as a drop, with no egress output.
- R11: During the lookup cycle and during tag and header replay, `in_ready` of that ingress port is low. An offered tag or header byte holds its value while `out_ready` is low.
- R12: Bytes arriving on an idle ingress port without `in_sop` are consumed and discarded. They produce no output and do not change the drop counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | NPORTS | Ingress byte valid, one bit per port |
| in_data | input | NPORTS*DATA_W | Ingress bytes, port p at bits p*DATA_W upward |
| in_sop | input | NPORTS | First byte of a frame |
| in_eop | input | NPORTS | Last byte of a frame |
| in_ready | output | NPORTS | Ingress byte accepted when high with valid |
| out_valid | output | NPORTS | Egress byte valid |
| out_data | output | NPORTS*DATA_W | Egress bytes |
| out_sop | output | NPORTS | Egress tag byte marker |
| out_eop | output | NPORTS | Egress last byte marker |
| out_ready | input | NPORTS | Egress sink ready |
| tbl_we | input | 1 | Table write strobe |
| tbl_idx | input | log2(ENTRIES) | Entry to write |
| tbl_value | input | ADDR_W | Entry compare value |
| tbl_mask | input | ADDR_W | Entry care mask, 1 = compare |
| tbl_port | input | log2(NPORTS) | Entry egress port |
| tbl_valid | input | 1 | Entry valid flag written |
| dflt_port | input | log2(NPORTS) | Egress port on a miss |
| drop_count | output | NPORTS*CNT_W | Per-ingress discarded-frame counters, wrapping |

## Verification
The embedded properties assume well-formed ingress traffic. Frames start with `in_sop` only on an idle port, end with exactly one `in_eop`, and an offered byte is not withdrawn or changed before it is accepted. They also assume table writes never target an entry during a cycle in which that entry's lookup result is being consumed. The bench drives each ingress port from a single task that holds valid, data and markers steady until it sees `in_ready` high at the preceding negative edge. It writes the table only while no frame is in its lookup cycle. The runt and stray-byte cases deliberately violate the frame-length and start-marker expectations, but only in ways the block is specified to absorb.

// File: rtl/csw_pkg.sv
package csw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_REQ,
    ST_FWD,
    ST_PASS,
    ST_DROP
  } ing_state_e;
endpackage

// File: rtl/csw_tcam.sv
module csw_tcam #(
  parameter int NPORTS  = 4,
  parameter int ADDR_W  = 48,
  parameter int ENTRIES = 16,
  parameter int PORT_W  = 2,
  parameter int IDX_W   = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [IDX_W-1:0]          wr_idx,
  input  logic [ADDR_W-1:0]         wr_value,
  input  logic [ADDR_W-1:0]         wr_mask,
  input  logic [PORT_W-1:0]         wr_port,
  input  logic                      wr_valid,
  input  logic [PORT_W-1:0]         dflt_port,
  input  logic [NPORTS*ADDR_W-1:0]  keys,
  output logic [NPORTS*PORT_W-1:0]  res_port
);
  logic [ADDR_W-1:0]  val_q [ENTRIES];
  logic [ADDR_W-1:0]  msk_q [ENTRIES];
  logic [PORT_W-1:0]  prt_q [ENTRIES];
  logic [ENTRIES-1:0] vld_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int e = 0; e < ENTRIES; e++) begin
        val_q[e] <= '0;
        msk_q[e] <= '0;
        prt_q[e] <= '0;
      end
    end else if (wr_en) begin
      val_q[wr_idx] <= wr_value;
      msk_q[wr_idx] <= wr_mask;
      prt_q[wr_idx] <= wr_port;
      vld_q[wr_idx] <= wr_valid;
    end
  end

  // one match unit per ingress key; lowest matching index wins
  for (genvar g = 0; g < NPORTS; g++) begin : g_look
    logic [ADDR_W-1:0] key;
    logic [PORT_W-1:0] sel;
    assign key = keys[g*ADDR_W +: ADDR_W];
    always_comb begin
      sel = dflt_port;
      for (int e = ENTRIES - 1; e >= 0; e--) begin
        if (vld_q[e] && (((key ^ val_q[e]) & msk_q[e]) == '0)) sel = prt_q[e];
      end
    end
    assign res_port[g*PORT_W +: PORT_W] = sel;
  end

  AST_TBL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (vld_q[$past(wr_idx)] == $past(wr_valid)) && (prt_q[$past(wr_idx)] == $past(wr_port))); // R2
endmodule

// File: rtl/csw_ingress.sv
module csw_ingress
  import csw_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 48,
  parameter int PORT_W = 2,
  parameter int CNT_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [DATA_W-1:0]  in_data,
  input  logic               in_sop,
  input  logic               in_eop,
  output logic               in_ready,
  output logic [ADDR_W-1:0]  key,
  input  logic [PORT_W-1:0]  look_port,
  output logic               req,
  output logic [PORT_W-1:0]  req_port,
  input  logic               grant,
  output logic               eg_valid,
  output logic [DATA_W-1:0]  eg_data,
  output logic               eg_sop,
  output logic               eg_eop,
  input  logic               eg_ready,
  output logic               done,
  output logic [CNT_W-1:0]   drop_cnt
);
  localparam int HDR_N = ADDR_W / DATA_W;
  localparam int IDX_W = $clog2(HDR_N + 1);

  ing_state_e        st_q, st_d;
  logic [DATA_W-1:0] hdr_q [HDR_N];
  logic [IDX_W-1:0]  idx_q;
  logic [PORT_W-1:0] port_q;
  logic [CNT_W-1:0]  drop_q;
  logic              drop_inc;
  logic [DATA_W-1:0] hdr_sel;

  assign drop_cnt = drop_q;
  assign req_port = look_port;

  always_comb begin
    key = '0;
    for (int b = 0; b < HDR_N; b++) key[ADDR_W-1-b*DATA_W -: DATA_W] = hdr_q[b];
  end

  // replay index 1..HDR_N selects header byte index-1
  always_comb begin
    hdr_sel = '0;
    for (int b = 0; b < HDR_N; b++) begin
      if (idx_q == IDX_W'(b + 1)) hdr_sel = hdr_q[b];
    end
  end

  always_comb begin
    st_d     = st_q;
    in_ready = 1'b0;
    req      = 1'b0;
    eg_valid = 1'b0;
    eg_data  = '0;
    eg_sop   = 1'b0;
    eg_eop   = 1'b0;
    done     = 1'b0;
    drop_inc = 1'b0;
    case (st_q)
      ST_IDLE: begin
        in_ready = 1'b1;
        if (in_valid && in_sop) begin
          if (in_eop) drop_inc = 1'b1;
          else        st_d = ST_HDR;
        end
      end
      ST_HDR: begin
        in_ready = 1'b1;
        if (in_valid) begin
          if (in_eop) begin
            drop_inc = 1'b1;
            st_d     = ST_IDLE;
          end else if (idx_q == IDX_W'(HDR_N - 1)) begin
            st_d = ST_REQ;
          end
        end
      end
      ST_REQ: begin
        req  = 1'b1;
        st_d = grant ? ST_FWD : ST_DROP;
      end
      ST_FWD: begin
        eg_valid = 1'b1;
        eg_sop   = (idx_q == '0);
        eg_data  = (idx_q == '0) ? DATA_W'(port_q) : hdr_sel;
        if (eg_ready && idx_q == IDX_W'(HDR_N)) st_d = ST_PASS;
      end
      ST_PASS: begin
        eg_valid = in_valid;
        eg_data  = in_data;
        eg_eop   = in_eop;
        in_ready = eg_ready;
        if (in_valid && eg_ready && in_eop) begin
          done = 1'b1;
          st_d = ST_IDLE;
        end
      end
      ST_DROP: begin
        in_ready = 1'b1;
        if (in_valid && in_eop) begin
          drop_inc = 1'b1;
          st_d     = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      port_q <= '0;
      drop_q <= '0;
      for (int b = 0; b < HDR_N; b++) hdr_q[b] <= '0;
    end else begin
      st_q <= st_d;
      if (drop_inc) drop_q <= drop_q + 1'b1;
      case (st_q)
        ST_IDLE: if (in_valid && in_sop) begin
          hdr_q[0] <= in_data;
          idx_q    <= IDX_W'(1);
        end
        ST_HDR: if (in_valid) begin
          for (int b = 1; b < HDR_N; b++) begin
            if (idx_q == IDX_W'(b)) hdr_q[b] <= in_data;
          end
          idx_q <= idx_q + 1'b1;
        end
        ST_REQ: begin
          port_q <= look_port;
          idx_q  <= '0;
        end
        ST_FWD: if (eg_ready && idx_q != IDX_W'(HDR_N)) idx_q <= idx_q + 1'b1;
        default: ;
      endcase
    end
  end

  AST_REQ_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_REQ) |-> !in_ready); // R11

  AST_REPLAY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FWD && !eg_ready) |=> (eg_valid && $stable(eg_data) && $stable(eg_sop))); // R11

  AST_DROP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_q == $past(drop_q)) || (drop_q == $past(drop_q) + 1'b1)); // R7

  AST_DROP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DROP) |=> (st_q != ST_PASS)); // R7
endmodule

// File: rtl/csw_egress.sv
module csw_egress #(
  parameter int NPORTS = 4,
  parameter int DATA_W = 8,
  parameter int PORT_W = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NPORTS-1:0]          req,
  input  logic [NPORTS*PORT_W-1:0]   req_port,
  input  logic [NPORTS-1:0]          done,
  output logic [NPORTS-1:0]          grant,
  input  logic [NPORTS-1:0]          ing_valid,
  input  logic [NPORTS*DATA_W-1:0]   ing_data,
  input  logic [NPORTS-1:0]          ing_sop,
  input  logic [NPORTS-1:0]          ing_eop,
  output logic [NPORTS-1:0]          ing_ready,
  output logic [NPORTS-1:0]          out_valid,
  output logic [NPORTS*DATA_W-1:0]   out_data,
  output logic [NPORTS-1:0]          out_sop,
  output logic [NPORTS-1:0]          out_eop,
  input  logic [NPORTS-1:0]          out_ready
);
  logic [NPORTS-1:0] owner_vld_q;
  logic [PORT_W-1:0] owner_q [NPORTS];
  logic [PORT_W-1:0] rp      [NPORTS];
  logic [NPORTS-1:0] hits    [NPORTS];
  logic [NPORTS-1:0] taken;

  for (genvar i = 0; i < NPORTS; i++) begin : g_rp
    assign rp[i] = req_port[i*PORT_W +: PORT_W];
  end

  // per-egress fixed priority: lowest ingress index first, busy port grants nothing
  always_comb begin
    grant = '0;
    taken = '0;
    for (int e = 0; e < NPORTS; e++) begin
      hits[e]  = '0;
      taken[e] = owner_vld_q[e];
      for (int i = 0; i < NPORTS; i++) begin
        if (req[i] && rp[i] == PORT_W'(e)) begin
          hits[e][i] = 1'b1;
          if (!taken[e]) begin
            grant[i] = 1'b1;
            taken[e] = 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    ing_ready = '0;
    for (int e = 0; e < NPORTS; e++) begin
      if (owner_vld_q[e]) ing_ready[owner_q[e]] = out_ready[e];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owner_vld_q <= '0;
      for (int e = 0; e < NPORTS; e++) owner_q[e] <= '0;
    end else begin
      for (int e = 0; e < NPORTS; e++) begin
        if (owner_vld_q[e] && done[owner_q[e]]) owner_vld_q[e] <= 1'b0;
      end
      for (int i = 0; i < NPORTS; i++) begin
        if (grant[i]) begin
          owner_vld_q[rp[i]] <= 1'b1;
          owner_q[rp[i]]     <= PORT_W'(i);
        end
      end
    end
  end

  for (genvar e = 0; e < NPORTS; e++) begin : g_out
    assign out_valid[e]                 = owner_vld_q[e] & ing_valid[owner_q[e]];
    assign out_data[e*DATA_W +: DATA_W] = ing_data[owner_q[e]*DATA_W +: DATA_W];
    assign out_sop[e]                   = owner_vld_q[e] & ing_sop[owner_q[e]];
    assign out_eop[e]                   = owner_vld_q[e] & ing_eop[owner_q[e]];

    AST_OWNER_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (owner_vld_q[e] && !done[owner_q[e]]) |=> (owner_vld_q[e] && owner_q[e] == $past(owner_q[e]))); // R9

    AST_SINGLE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant & hits[e])); // R8

    AST_BUSY_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      owner_vld_q[e] |-> ((grant & hits[e]) == '0)); // R7
  end
endmodule

// File: rtl/csw_fwd_engine.sv
module csw_fwd_engine #(
  parameter int NPORTS  = 4,
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 48,
  parameter int ENTRIES = 16,
  parameter int CNT_W   = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NPORTS-1:0]             in_valid,
  input  logic [NPORTS*DATA_W-1:0]      in_data,
  input  logic [NPORTS-1:0]             in_sop,
  input  logic [NPORTS-1:0]             in_eop,
  output logic [NPORTS-1:0]             in_ready,
  output logic [NPORTS-1:0]             out_valid,
  output logic [NPORTS*DATA_W-1:0]      out_data,
  output logic [NPORTS-1:0]             out_sop,
  output logic [NPORTS-1:0]             out_eop,
  input  logic [NPORTS-1:0]             out_ready,
  input  logic                          tbl_we,
  input  logic [$clog2(ENTRIES)-1:0]    tbl_idx,
  input  logic [ADDR_W-1:0]             tbl_value,
  input  logic [ADDR_W-1:0]             tbl_mask,
  input  logic [$clog2(NPORTS)-1:0]     tbl_port,
  input  logic                          tbl_valid,
  input  logic [$clog2(NPORTS)-1:0]     dflt_port,
  output logic [NPORTS*CNT_W-1:0]       drop_count
);
  localparam int PORT_W = $clog2(NPORTS);
  localparam int IDX_W  = $clog2(ENTRIES);

  logic [NPORTS*ADDR_W-1:0] keys;
  logic [NPORTS*PORT_W-1:0] look_port;
  logic [NPORTS*PORT_W-1:0] req_port;
  logic [NPORTS-1:0]        req, grant, done;
  logic [NPORTS-1:0]        eg_valid, eg_sop, eg_eop, eg_ready;
  logic [NPORTS*DATA_W-1:0] eg_data;

  csw_tcam #(
    .NPORTS(NPORTS), .ADDR_W(ADDR_W), .ENTRIES(ENTRIES), .PORT_W(PORT_W), .IDX_W(IDX_W)
  ) u_tcam (
    .clk(clk), .rst_n(rst_n),
    .wr_en(tbl_we), .wr_idx(tbl_idx), .wr_value(tbl_value), .wr_mask(tbl_mask),
    .wr_port(tbl_port), .wr_valid(tbl_valid), .dflt_port(dflt_port),
    .keys(keys), .res_port(look_port)
  );

  for (genvar p = 0; p < NPORTS; p++) begin : g_ing
    csw_ingress #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PORT_W(PORT_W), .CNT_W(CNT_W)
    ) u_ing (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid[p]), .in_data(in_data[p*DATA_W +: DATA_W]),
      .in_sop(in_sop[p]), .in_eop(in_eop[p]), .in_ready(in_ready[p]),
      .key(keys[p*ADDR_W +: ADDR_W]), .look_port(look_port[p*PORT_W +: PORT_W]),
      .req(req[p]), .req_port(req_port[p*PORT_W +: PORT_W]), .grant(grant[p]),
      .eg_valid(eg_valid[p]), .eg_data(eg_data[p*DATA_W +: DATA_W]),
      .eg_sop(eg_sop[p]), .eg_eop(eg_eop[p]), .eg_ready(eg_ready[p]),
      .done(done[p]), .drop_cnt(drop_count[p*CNT_W +: CNT_W])
    );
  end

  csw_egress #(
    .NPORTS(NPORTS), .DATA_W(DATA_W), .PORT_W(PORT_W)
  ) u_egress (
    .clk(clk), .rst_n(rst_n),
    .req(req), .req_port(req_port), .done(done), .grant(grant),
    .ing_valid(eg_valid), .ing_data(eg_data), .ing_sop(eg_sop), .ing_eop(eg_eop),
    .ing_ready(eg_ready),
    .out_valid(out_valid), .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop),
    .out_ready(out_ready)
  );
endmodule

// File: tb/csw_fwd_engine_tb.sv
`timescale 1ns/1ps
module csw_fwd_engine_tb;
  localparam int NP = 4;
  localparam int CW = 16;
  localparam logic [47:0] DA_A = 48'h02_00_00_00_00_01;
  localparam logic [47:0] DA_B = 48'h02_00_00_00_00_05;
  localparam logic [47:0] DA_C = 48'h0A_11_22_33_44_55;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [NP-1:0]    in_valid = '0, in_sop = '0, in_eop = '0, in_ready;
  logic [NP*8-1:0]  in_data = '0;
  logic [NP-1:0]    out_valid, out_sop, out_eop;
  logic [NP-1:0]    out_ready = '1;
  logic [NP*8-1:0]  out_data;
  logic             tbl_we = 1'b0, tbl_valid = 1'b0;
  logic [3:0]       tbl_idx = '0;
  logic [47:0]      tbl_value = '0, tbl_mask = '0;
  logic [1:0]       tbl_port = '0;
  logic [1:0]       dflt_port = 2'd3;
  logic [NP*CW-1:0] drop_count;

  csw_fwd_engine u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop),
    .out_ready(out_ready),
    .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_value(tbl_value), .tbl_mask(tbl_mask),
    .tbl_port(tbl_port), .tbl_valid(tbl_valid), .dflt_port(dflt_port),
    .drop_count(drop_count)
  );

  int runs = 0;
  int fails = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // egress monitor: {sop, eop, data} per transferred byte
  logic [9:0] mbuf [NP][512];
  int         mcyc [NP][512];
  int         mn   [NP];
  initial for (int e = 0; e < NP; e++) mn[e] = 0;
  always @(negedge clk) begin
    for (int e = 0; e < NP; e++) begin
      if (out_valid[e] && out_ready[e] && mn[e] < 512) begin
        mbuf[e][mn[e]] = {out_sop[e], out_eop[e], out_data[e*8 +: 8]};
        mcyc[e][mn[e]] = cyc;
        mn[e] = mn[e] + 1;
      end
    end
  end

  logic [7:0] frm [NP][64];
  int  flen     [NP];
  int  hdr_cyc  [NP];
  int  last_cyc [NP];
  bit  stall_seen [NP];

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    runs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int dc(int p);
    return int'(drop_count[p*CW +: CW]);
  endfunction

  function automatic int total_out();
    int s = 0;
    for (int e = 0; e < NP; e++) s += mn[e];
    return s;
  endfunction

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic write_entry(int idx, logic [47:0] v, logic [47:0] m, int prt, bit vld);
    tbl_we = 1'b1; tbl_idx = 4'(idx); tbl_value = v; tbl_mask = m;
    tbl_port = 2'(prt); tbl_valid = vld;
    @(posedge clk); #1;
    tbl_we = 1'b0;
  endtask

  task automatic build(int p, logic [47:0] da, int len, logic [7:0] seed);
    flen[p] = len;
    for (int k = 0; k < len; k++)
      frm[p][k] = (k < 6) ? da[47-8*k -: 8] : 8'(seed + 8'(k));
  endtask

  task automatic send(int p, bit with_sop);
    for (int k = 0; k < flen[p]; k++) begin
      bit ok;
      bit first = 1'b1;
      in_valid[p] = 1'b1;
      in_data[p*8 +: 8] = frm[p][k];
      in_sop[p] = (k == 0) && with_sop;
      in_eop[p] = (k == flen[p] - 1);
      forever begin
        @(negedge clk);
        ok = in_ready[p];
        if (k == 6 && first) stall_seen[p] = !ok;
        first = 1'b0;
        @(posedge clk); #1;
        if (ok) break;
      end
      if (k == 5) hdr_cyc[p] = cyc;
    end
    last_cyc[p] = cyc;
    in_valid[p] = 1'b0; in_sop[p] = 1'b0; in_eop[p] = 1'b0;
  endtask

  task automatic chk_frame(int e, int p, int base, string req);
    bit ok = (mn[e] - base == flen[p] + 1);
    longint act = mn[e] - base;
    longint exp = flen[p] + 1;
    if (ok && mbuf[e][base] != {2'b10, 8'(e)}) begin
      ok = 1'b0; act = mbuf[e][base]; exp = {2'b10, 8'(e)};
    end
    for (int k = 0; ok && k < flen[p]; k++) begin
      logic [9:0] want = {1'b0, k == flen[p] - 1, frm[p][k]};
      if (mbuf[e][base+1+k] != want) begin
        ok = 1'b0; act = mbuf[e][base+1+k]; exp = want;
      end
    end
    chk(ok, req, $sformatf("egress %0d frame from ingress %0d", e, p), act, exp);
  endtask

  task automatic t_reset();
    chk(out_valid == '0, "R1", "out_valid after reset", out_valid, 0);
    chk(in_ready == '1, "R1", "in_ready after reset", in_ready, 4'hF);
    chk(drop_count == '0, "R1", "drop counters after reset", drop_count, 0);
    begin
      int b = mn[3];
      build(0, DA_A, 9, 8'h10);
      send(0, 1'b1); idle(3);
      chk_frame(3, 0, b, "R1 empty table uses default");
    end
  endtask

  task automatic t_routes();
    int b;
    b = mn[2];
    build(0, DA_A, 12, 8'h20); send(0, 1'b1); idle(3);
    chk_frame(2, 0, b, "R4 lowest index of two matches");
    b = mn[1];
    build(1, DA_B, 10, 8'h30); send(1, 1'b1); idle(3);
    chk_frame(1, 1, b, "R3 masked match");
    b = mn[3];
    build(2, DA_C, 8, 8'h50); send(2, 1'b1); idle(3);
    chk_frame(3, 2, b, "R4 miss to default, R2 invalid entry ignored");
  endtask

  task automatic t_cut_through();
    int b = mn[2];
    build(3, DA_A, 30, 8'h60); send(3, 1'b1); idle(3);
    chk_frame(2, 3, b, "R5 tag plus intact frame");
    chk(mcyc[2][b] == hdr_cyc[3] + 1, "R6", "tag cycle after header", mcyc[2][b], hdr_cyc[3] + 1);
    chk(mcyc[2][b] < last_cyc[3], "R6", "tag before frame tail", mcyc[2][b], last_cyc[3]);
    chk(stall_seen[3], "R11", "in_ready low after header", 0, 1);
  endtask

  task automatic t_backpressure();
    int b = mn[2];
    build(0, DA_A, 16, 8'h70);
    fork
      send(0, 1'b1);
      begin
        for (int j = 0; j < 60; j++) begin
          out_ready[2] = (j % 3) != 0;
          @(posedge clk); #1;
        end
        out_ready[2] = 1'b1;
      end
    join
    idle(3);
    chk_frame(2, 0, b, "R11 stalled egress keeps bytes");
  endtask

  task automatic t_congestion();
    int b = mn[2];
    int d0 = dc(0);
    int d1 = dc(1);
    build(0, DA_A, 40, 8'h80);
    build(1, DA_A, 10, 8'hA0);
    fork
      send(0, 1'b1);
      begin idle(15); send(1, 1'b1); end
    join
    idle(3);
    chk_frame(2, 0, b, "R9 owning frame completes");
    chk(dc(1) == d1 + 1, "R7", "drop count of blocked ingress", dc(1), d1 + 1);
    chk(dc(0) == d0, "R7", "drop count of owner unchanged", dc(0), d0);
    b = mn[2];
    send(1, 1'b1); idle(3);
    chk_frame(2, 1, b, "R9 egress free after release");
  endtask

  task automatic t_same_cycle();
    int b = mn[1];
    int d1 = dc(1);
    int d3 = dc(3);
    build(1, DA_B, 9, 8'h40);
    build(3, DA_B, 9, 8'hC0);
    fork
      send(1, 1'b1);
      send(3, 1'b1);
    join
    idle(3);
    chk_frame(1, 1, b, "R8 lowest ingress wins");
    chk(dc(3) == d3 + 1, "R8", "loser drop count", dc(3), d3 + 1);
    chk(dc(1) == d1, "R8", "winner drop count", dc(1), d1);
  endtask

  task automatic t_runt();
    int t = total_out();
    int d2 = dc(2);
    build(2, DA_A, 4, 8'h00); send(2, 1'b1); idle(2);
    build(2, DA_A, 6, 8'h00); send(2, 1'b1); idle(3);
    chk(dc(2) == d2 + 2, "R10", "runt drop count", dc(2), d2 + 2);
    chk(total_out() == t, "R10", "runt egress bytes", total_out() - t, 0);
  endtask

  task automatic t_stray();
    int t = total_out();
    int d0 = dc(0);
    int b;
    build(0, DA_A, 3, 8'h00); send(0, 1'b0); idle(3);
    chk(total_out() == t, "R12", "stray bytes output", total_out() - t, 0);
    chk(dc(0) == d0, "R12", "stray bytes drop count", dc(0), d0);
    b = mn[1];
    build(0, DA_B, 8, 8'h90); send(0, 1'b1); idle(3);
    chk_frame(1, 0, b, "R12 next frame after stray bytes");
  endtask

  task automatic t_rewrite();
    int b = mn[0];
    write_entry(0, DA_A, 48'hFFFF_FFFF_FFFF, 0, 1'b1);
    build(2, DA_A, 11, 8'hB0); send(2, 1'b1); idle(3);
    chk_frame(0, 2, b, "R2 rewritten entry port");
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(1);
    t_reset();
    write_entry(0, DA_A, 48'hFFFF_FFFF_FFFF, 2, 1'b1);
    write_entry(1, 48'h02_00_00_00_00_00, 48'hFFFF_FFFF_FFF0, 1, 1'b1);
    write_entry(2, 48'h0, 48'h0, 0, 1'b0);
    idle(1);
    t_routes();
    t_cut_through();
    t_backpressure();
    t_congestion();
    t_same_cycle();
    t_runt();
    t_stray();
    t_rewrite();
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    runs++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule